// File: doc/BRIEF.md
# Multi-Channel Event Timestamp Recorder

The recorder watches a small set of asynchronous event inputs. It synchronises each input and treats each rising edge as one event. For every channel it keeps a status flag, a saturating event count, the calendar time of the first event since the channel was last cleared, and the calendar time of the most recent event. The calendar time arrives as one packed word from a clock block that lives outside the recorder.

Software reads the status flags, the packed counters and the stamps through a combinational read port that is selected by an address. Software acknowledges a channel by writing a one to that channel's status bit. This clears the flag and restarts the count. The first stamp then becomes free to capture again, and the last stamp keeps following every event.

Top module: `evrec_top`

## Requirements
- R1: An event is a rising edge on `ev_in[ch]`. The input passes through a two-flop synchroniser followed by one edge-detect flop. The channel state changes at the third rising clock edge after the input goes high. An input that stays high counts once, and a falling edge counts nothing.
- R2: Each channel counter is 3 bits wide. It adds one per event and stays at 7 once it gets there.
- R3: A write to address 0 clears the status bit of every channel whose `wr_data` bit is one, and sets that channel's counter to 0. Channels whose `wr_data` bit is zero are left unchanged.
- R4: When an event sets a channel's status bit from 0 to 1, the first stamp of that channel takes the value of `tm_in`. The first stamp then holds that value until the status bit is cleared.
- R5: On every event, the last stamp of the channel takes the value of `tm_in`.
- R6: Address 1 returns the counters with channel 0 in bits 2:0, channel 1 in bits 10:8 and channel 2 in bits 18:16. All other bits read as zero.
- R7: The stamp layout is seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and day of year in bits 25:17, both in `tm_in` and in a stamp read. Bits 31:26 of a stamp read are zero.
- R8: If an event and a clear of the same channel fall in the same cycle, the event wins. The status bit stays 1, the counter becomes 1, and both stamps take the value of `tm_in`.
- R9: After reset all status bits and counters are 0. Stamps have no reset value and are meaningful only while the channel's status bit is 1.
- R10: The read map is: address 0 gives the status flags in bits 2:0, address 2+ch gives the first stamp of channel ch, and address 5+ch gives the last stamp of channel ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | 3 | Asynchronous event inputs, one per channel |
| tm_in | input | 26 | Packed calendar time: seconds, minutes, hours, day of year |
| addr | input | 3 | Register address for both read and write |
| wr_en | input | 1 | Write strobe; acts only when addr is 0 |
| wr_data | input | 3 | Write-one-to-clear mask for the status bits |
| rd_data | output | 32 | Combinational read data for addr |

## Verification
The assertions assume that `tm_in` is stable at the clock edge where a capture happens. They also assume that an event pulse is visible for exactly one cycle, which holds because events only come from the edge detector. The stamp checks compare against the sampled time only after a capture has set the status bit, so stamps that were never written are never compared. The bench changes `tm_in` and `ev_in` only on falling clock edges and keeps `ev_in` low through reset. It lines up each same-cycle clear with the one cycle in which the edge detector fires, because otherwise the race case of R8 would not be reached.

// File: rtl/evrec_pkg.sv
// Package: shared widths, the packed calendar stamp type and the register map.
// Assumes a 32-bit read word and a calendar time of 26 significant bits.
package evrec_pkg;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DOY_W   = 9;
    localparam int STAMP_W = SEC_W + MIN_W + HOUR_W + DOY_W;
    localparam int REG_W   = 32;
    localparam int LANE_W  = 8;

    // Seconds in the low bits, day of year in the high bits.
    typedef struct packed {
        logic [DOY_W-1:0]  doy;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } stamp_t;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_COUNT  = 1;
    localparam int ADDR_FIRST0 = 2;
endpackage

// File: rtl/evrec_edge_detect.sv
// Module: per-channel synchroniser and rising-edge detector.
// Each input goes through SYNC_STAGES flops and then one history flop.
// A one-cycle pulse comes out when the synchronised level rises.
// Assumes the inputs are held low during reset, so no false edge appears on release.
module evrec_edge_detect #(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_async,
    output logic [NUM_CH-1:0] ev_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CHAIN_W-1:0] chain_q;

        // Shift the raw level through the synchroniser and the history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN_W-2:0], ev_async[ch]};
            end
        end

        // The synchronised level is high and the history flop is still low.
        always_comb begin
            ev_pulse[ch] = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
        end
    end
endmodule

// File: rtl/evrec_channel.sv
// Module: state of one recorder channel.
// Holds the status flag, the saturating counter and the first and last stamps.
// An event that arrives in the same cycle as a clear wins over the clear.
// The stamps have no reset; they are valid only while status is set.
module evrec_channel
    import evrec_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    input  stamp_t           tm,
    output logic             status,
    output logic [CNT_W-1:0] cnt,
    output stamp_t           first,
    output stamp_t           last
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic restart;
    logic [CNT_W-1:0] cnt_next;

    // A channel restarts when an event finds it idle or races a clear.
    always_comb begin
        restart = evt & (clr | ~status);
    end

    // Work out the next count: 1 on a restart, otherwise add one and stop at CNT_MAX.
    always_comb begin
        if (restart) begin
            cnt_next = CNT_W'(1);
        end else if (cnt == CNT_MAX) begin
            cnt_next = CNT_MAX;
        end else begin
            cnt_next = cnt + CNT_W'(1);
        end
    end

    // Update the status flag and the counter; an event takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
            cnt    <= '0;
        end else if (evt) begin
            status <= 1'b1;
            cnt    <= cnt_next;
        end else if (clr) begin
            status <= 1'b0;
            cnt    <= '0;
        end
    end

    // Capture the first stamp only when the channel restarts.
    always_ff @(posedge clk) begin
        if (restart) begin
            first <= tm;
        end
    end

    // Capture the last stamp on every event.
    always_ff @(posedge clk) begin
        if (evt) begin
            last <= tm;
        end
    end
endmodule

// File: rtl/evrec_readmux.sv
// Module: combinational register read multiplexer.
// Packs the status flags, the counter lanes and the zero-extended stamps into one read word.
// Assumes 2 + 2*NUM_CH addresses fit in ADDR_W bits.
module evrec_readmux
    import evrec_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_CH-1:0]              status,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
    input  logic [NUM_CH-1:0][STAMP_W-1:0] first,
    input  logic [NUM_CH-1:0][STAMP_W-1:0] last,
    output logic [REG_W-1:0]               rd_data
);
    localparam int LAST0 = ADDR_FIRST0 + NUM_CH;

    logic [REG_W-1:0] cnt_word;

    // Place each counter in the low bits of its own 8-bit lane.
    always_comb begin
        cnt_word = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            cnt_word[ch*LANE_W +: CNT_W] = cnt[ch];
        end
    end

    // Select the word for the current address; addresses with no register read zero.
    always_comb begin
        rd_data = '0;
        if (int'(addr) == ADDR_STATUS) begin
            rd_data[NUM_CH-1:0] = status;
        end else if (int'(addr) == ADDR_COUNT) begin
            rd_data = cnt_word;
        end else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (int'(addr) == ADDR_FIRST0 + ch) begin
                    rd_data[STAMP_W-1:0] = first[ch];
                end
                if (int'(addr) == LAST0 + ch) begin
                    rd_data[STAMP_W-1:0] = last[ch];
                end
            end
        end
    end
endmodule

// File: rtl/evrec_top.sv
// Module: multi-channel event timestamp recorder, top level.
// Synchronises the event inputs, keeps the per-channel state and serves register reads.
// A write to the status address clears every channel whose write bit is one.
// Assumes tm_in comes from a clock that is synchronous to clk.
module evrec_top
    import evrec_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  ev_in,
    input  logic [STAMP_W-1:0] tm_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [NUM_CH-1:0]  wr_data,
    output logic [REG_W-1:0]   rd_data
);
    logic [NUM_CH-1:0]              evt_pulse;
    logic [NUM_CH-1:0]              clr_vec;
    logic [NUM_CH-1:0]              status_q;
    logic [NUM_CH-1:0][CNT_W-1:0]   cnt_q;
    logic [NUM_CH-1:0][STAMP_W-1:0] first_q;
    logic [NUM_CH-1:0][STAMP_W-1:0] last_q;
    stamp_t                         tm_s;

    // View the raw time word as a calendar stamp.
    always_comb begin
        tm_s = stamp_t'(tm_in);
    end

    // Decode the write-one-to-clear strobe for each channel.
    always_comb begin
        clr_vec = (wr_en && int'(addr) == ADDR_STATUS) ? wr_data : '0;
    end

    evrec_edge_detect #(
        .NUM_CH      (NUM_CH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_async (ev_in),
        .ev_pulse (evt_pulse)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        stamp_t first_s;
        stamp_t last_s;

        evrec_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_pulse[ch]),
            .clr    (clr_vec[ch]),
            .tm     (tm_s),
            .status (status_q[ch]),
            .cnt    (cnt_q[ch]),
            .first  (first_s),
            .last   (last_s)
        );

        // Flatten the stamps so the read mux and the checker can index them.
        always_comb begin
            first_q[ch] = first_s;
            last_q[ch]  = last_s;
        end
    end

    evrec_readmux #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .addr    (addr),
        .status  (status_q),
        .cnt     (cnt_q),
        .first   (first_q),
        .last    (last_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/evrec_chk.sv
// Module: property checker for evrec_top, attached by bind.
// Assumes event pulses only come from the edge detector and tm_in is stable at capture edges.
module evrec_chk
    import evrec_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CH-1:0]              evt,
    input logic [NUM_CH-1:0]              clr,
    input logic [NUM_CH-1:0]              status,
    input logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
    input logic [NUM_CH-1:0][STAMP_W-1:0] first,
    input logic [NUM_CH-1:0][STAMP_W-1:0] last,
    input logic [STAMP_W-1:0]             tm
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_p
        // R1: an edge gives a pulse of exactly one cycle
        p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
            evt[ch] |=> !evt[ch]);
        // R2: counting up below the limit
        p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[ch] && !clr[ch] && status[ch] && cnt[ch] != CNT_MAX)
                |=> cnt[ch] == $past(cnt[ch]) + CNT_W'(1));
        // R2: the counter stays at its limit
        p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[ch] == CNT_MAX && !clr[ch]) |=> cnt[ch] == CNT_MAX);
        // R3: a clear without an event empties the channel
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[ch] && !evt[ch]) |=> (!status[ch] && cnt[ch] == '0));
        // R9: an idle channel has a zero count
        p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !status[ch] |-> cnt[ch] == '0);
        // R4: the first stamp is captured on the 0 to 1 change
        p_first_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[ch] && !status[ch]) |=> first[ch] == $past(tm));
        // R4: the first stamp holds while the channel stays set
        p_first_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (status[ch] && !clr[ch]) |=> $stable(first[ch]));
        // R5: the last stamp follows every event
        p_last_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            evt[ch] |=> last[ch] == $past(tm));
        // R8: an event beats a clear in the same cycle
        p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[ch] && clr[ch]) |=> (status[ch] && cnt[ch] == CNT_W'(1)
                                      && first[ch] == $past(tm)));
    end
endmodule

bind evrec_top evrec_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_pulse),
    .clr    (clr_vec),
    .status (status_q),
    .cnt    (cnt_q),
    .first  (first_q),
    .last   (last_q),
    .tm     (tm_in)
);

// File: tb/tb_evrec_top.sv
module tb_evrec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ev_in = '0;
    logic [25:0] tm_in = '0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_data = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    evrec_top dut (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .tm_in(tm_in),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [25:0] mk(int s, int m, int h, int d);
        return 26'((d << 17) | (h << 12) | (m << 6) | s);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        addr = 3'(a);
        #1 v = rd_data;
    endtask

    task automatic clear(logic [2:0] mask);
        @(negedge clk);
        addr = 3'd0; wr_en = 1'b1; wr_data = mask;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // One full pulse on a channel, then let the synchroniser drain.
    task automatic pulse(int ch);
        @(negedge clk);
        ev_in[ch] = 1'b1;
        repeat (3) @(negedge clk);
        ev_in[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] cnt_word(int c0, int c1, int c2);
        return 32'(c0 | (c1 << 8) | (c2 << 16));
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [25:0] t_first;
        int exp_c[3];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(0, v); check("R9 status after reset", v, 32'h0);
        rd(1, v); check("R9 counters after reset", v, 32'h0);

        // Sweep each channel from 1 to 9 events with a new time for each event.
        for (int ch = 0; ch < 3; ch++) begin
            for (int n = 1; n <= 9; n++) begin
                @(negedge clk);
                tm_in = mk((n * 7 + ch) % 60, (n * 11 + ch * 5) % 60, (n + ch * 3) % 24, 100 * ch + n + 1);
                if (n == 1) t_first = tm_in;
                pulse(ch);
                exp_c = '{0, 0, 0};
                for (int k = 0; k < ch; k++) exp_c[k] = 7;
                exp_c[ch] = (n > 7) ? 7 : n;
                rd(1, v); check("R2 R6 counter word", v, cnt_word(exp_c[0], exp_c[1], exp_c[2]));
                rd(2 + ch, v); check("R4 R10 first stamp", v, {6'd0, t_first});
                rd(5 + ch, v); check("R5 R10 last stamp", v, {6'd0, tm_in});
            end
            rd(0, v); check("R10 status word", v, 32'((1 << (ch + 1)) - 1));
        end

        // Field layout of a stamp read.
        rd(2, v);
        check("R7 seconds", 32'(v[5:0]), 32'(7));
        check("R7 minutes", 32'(v[11:6]), 32'(11));
        check("R7 hours", 32'(v[16:12]), 32'(1));
        check("R7 day", 32'(v[25:17]), 32'(2));
        check("R7 upper bits", 32'(v[31:26]), 32'(0));

        // Writing zeros changes nothing; writing a one clears only that channel.
        clear(3'b000);
        rd(0, v); check("R3 zero write status", v, 32'h7);
        rd(1, v); check("R3 zero write counters", v, cnt_word(7, 7, 7));
        clear(3'b010);
        rd(0, v); check("R3 clear status", v, 32'h5);
        rd(1, v); check("R3 clear counter", v, cnt_word(7, 0, 7));

        // First stamp recaptures after a clear.
        @(negedge clk); tm_in = mk(42, 17, 9, 300);
        pulse(1);
        rd(3, v); check("R4 recapture", v, {6'd0, mk(42, 17, 9, 300)});
        rd(1, v); check("R3 count restart", v, cnt_word(7, 1, 7));

        // Latency and level: state changes at the third edge, and a held level counts once.
        @(negedge clk); tm_in = mk(1, 2, 3, 4);
        ev_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        addr = 3'd1; #1 check("R1 no change before third edge", rd_data, cnt_word(7, 1, 7));
        @(negedge clk);
        #1 check("R1 change at third edge", rd_data, cnt_word(7, 2, 7));
        repeat (10) @(negedge clk);
        #1 check("R1 held level counts once", rd_data, cnt_word(7, 2, 7));
        ev_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        #1 check("R1 falling edge ignored", rd_data, cnt_word(7, 2, 7));

        // Event and clear in the same cycle on channel 2.
        @(negedge clk); tm_in = mk(59, 59, 23, 366);
        ev_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        addr = 3'd0; wr_en = 1'b1; wr_data = 3'b100;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        ev_in[2] = 1'b0;
        rd(0, v); check("R8 status kept", v, 32'h7);
        rd(1, v); check("R8 counter one", v, cnt_word(7, 2, 1));
        rd(4, v); check("R8 first stamp", v, {6'd0, mk(59, 59, 23, 366)});
        rd(7, v); check("R8 last stamp", v, {6'd0, mk(59, 59, 23, 366)});
        repeat (4) @(negedge clk);

        // Clearing everything returns the channels to idle.
        clear(3'b111);
        rd(0, v); check("R3 clear all status", v, 32'h0);
        rd(1, v); check("R3 clear all counters", v, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule